// File: doc/BRIEF.md
# I/O Register Bit Access Unit

This block holds a bank of byte-wide I/O registers and carries out single-bit operations on them. On any clock cycle one operation may be presented: force one bit of a register to 1, force it to 0, or test one bit and report whether the instruction that follows should be skipped. A full-byte write is also provided, so that registers can be loaded directly. A combinational byte read port lets any register be observed at any time.

Only the lower part of the address space accepts single-bit operations. A bit operation aimed higher leaves every register as it was. It suppresses any skip and raises an illegal-operation flag for one cycle. The skip decision is registered, and it is valid in the single cycle that follows the test.

Top module: `iobit_unit`

## Requirements
- R1: After reset all 64 registers read 0x00, and `skipOut` and `illegalOut` are 0.
- R2: Operation code 5 (byte write) stores `wrData` into the register at `opAddr` for any address 0 to 63, visible after the next edge. `rdData` always shows the register selected by `rdAddr` combinationally.
- R3: Operation code 1 (bit set) with `opAddr` below 32 makes bit `bitIdx` (0 to 7) of that register 1 after the next edge.
- R4: Operation code 2 (bit clear) with `opAddr` below 32 makes bit `bitIdx` of that register 0 after the next edge.
- R5: A bit set or bit clear changes no other bit of the addressed register and no other register.
- R6: Operation code 3 (skip if set) with `opAddr` below 32 drives `skipOut` to 1 for exactly the cycle after the operation when the selected bit is 1, and to 0 otherwise.
- R7: Operation code 4 (skip if clear) with `opAddr` below 32 drives `skipOut` to 1 for exactly the cycle after the operation when the selected bit is 0, and to 0 otherwise.
- R8: Operation codes 1 to 4 with `opAddr` of 32 or above change no register, leave `skipOut` at 0, and drive `illegalOut` to 1 for exactly the following cycle.
- R9: Operation code 0 and the unused codes 6 and 7 change no register, and `skipOut` and `illegalOut` are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opCode | input | 3 | Operation: 0 none, 1 bit set, 2 bit clear, 3 skip if set, 4 skip if clear, 5 byte write |
| opAddr | input | 6 | Register address of the operation |
| bitIdx | input | 3 | Bit index for bit operations |
| wrData | input | 8 | Byte written by operation 5 |
| rdAddr | input | 6 | Register address for the read port |
| rdData | output | 8 | Contents of the register at `rdAddr` |
| skipOut | output | 1 | Registered skip decision of the previous test |
| illegalOut | output | 1 | Registered flag: previous bit operation was out of range |

## Verification
The bench builds the block with its default parameters: 64 registers of 8 bits, with bit access limited to the lower 32. At these values both sides of the boundary (31 and 32) and the top address 63 can be reached, and every bit index can be used. Directed sequences cover back-to-back tests, set and clear on the same bit, and illegal operations on preloaded upper registers. A seeded random stream of operations is then compared, cycle by cycle, against a behavioural model of the bank.

// File: rtl/iobit_pkg.sv
package iobit_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_SETB    = 3'd1,
    OP_CLRB    = 3'd2,
    OP_SKIPSET = 3'd3,
    OP_SKIPCLR = 3'd4,
    OP_WRBYTE  = 3'd5
  } ioOpE;

  // strobes from control to datapath
  typedef struct packed {
    logic wrBit;   // write one bit
    logic bitVal;  // value for that bit
    logic wrByte;  // write whole byte
  } ioStrbT;

endpackage

// File: rtl/iobit_datapath.sv
module iobit_datapath
  import iobit_pkg::*;
#(
  parameter int NUM_REGS  = 64,
  parameter int DATA_W    = 8,
  parameter int BIT_LIMIT = 32,
  localparam int ADDR_W   = $clog2(NUM_REGS),
  localparam int IDX_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ioStrbT            strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              selBit
);

  logic [DATA_W-1:0] bank [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic [DATA_W-1:0] q;
    logic              hit;
    assign hit = (addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= '0;
      end else if (strb.wrByte && hit) begin
        q <= wrData;
      end else if (strb.wrBit && hit) begin
        q[idx] <= strb.bitVal;
      end
    end

    assign bank[g] = q;
  end

  assign rdData = bank[rdAddr];
  assign selBit = bank[addr][idx];

  // R8: control never issues a bit write to the upper half
  a_r8_bit_write_in_range: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrBit |-> ({1'b0, addr} < (ADDR_W+1)'(BIT_LIMIT)));

  // R3/R4: a bit write lands with the requested value
  a_r3_bit_lands: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strb.wrBit) && !$past(strb.wrByte) &&
     $past(addr) == addr && $past(idx) == idx) |-> (selBit == $past(strb.bitVal)));

  // R2: a byte write is seen on the read port
  a_r2_byte_lands: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strb.wrByte) && rdAddr == $past(addr)) |-> (rdData == $past(wrData)));

endmodule

// File: rtl/iobit_control.sv
module iobit_control
  import iobit_pkg::*;
#(
  parameter int NUM_REGS  = 64,
  parameter int BIT_LIMIT = 32,
  localparam int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opCode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              selBit,
  output ioStrbT            strb,
  output logic              skip,
  output logic              illegal
);

  logic isSet, isClr, isTestSet, isTestClr, isBitOp, inRange, skipNext;

  assign isSet     = (opCode == OP_SETB);
  assign isClr     = (opCode == OP_CLRB);
  assign isTestSet = (opCode == OP_SKIPSET);
  assign isTestClr = (opCode == OP_SKIPCLR);
  assign isBitOp   = isSet | isClr | isTestSet | isTestClr;
  assign inRange   = ({1'b0, addr} < (ADDR_W+1)'(BIT_LIMIT));

  always_comb begin
    strb        = '0;
    strb.wrBit  = (isSet | isClr) & inRange;
    strb.bitVal = isSet;
    strb.wrByte = (opCode == OP_WRBYTE);
  end

  assign skipNext = inRange & ((isTestSet & selBit) | (isTestClr & ~selBit));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      skip    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      skip    <= skipNext;
      illegal <= isBitOp & ~inRange;
    end
  end

  // R8: an illegal operation never skips
  a_r8_illegal_no_skip: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !skip);

  // R6/R7: skip only follows a test operation
  a_r6_skip_after_test: assert property (@(posedge clk) disable iff (!rstN)
    skip |-> ($past(rstN) && ($past(opCode) == OP_SKIPSET || $past(opCode) == OP_SKIPCLR)));

  // R8: illegal only follows an out-of-range bit operation
  a_r8_illegal_source: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> ($past(rstN) && $past(addr) >= ADDR_W'(BIT_LIMIT) &&
                 $past(opCode) >= 3'd1 && $past(opCode) <= 3'd4));

  // R9: no-operation leaves both flags low
  a_r9_nop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ($past(opCode) == 3'd0 || $past(opCode) >= 3'd5)) |-> (!skip && !illegal));

endmodule

// File: rtl/iobit_unit.sv
module iobit_unit
  import iobit_pkg::*;
#(
  parameter int NUM_REGS  = 64,
  parameter int DATA_W    = 8,
  parameter int BIT_LIMIT = 32,
  localparam int ADDR_W   = $clog2(NUM_REGS),
  localparam int IDX_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opCode,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              skipOut,
  output logic              illegalOut
);

  ioStrbT strb;
  logic   selBit;

  iobit_control #(.NUM_REGS(NUM_REGS), .BIT_LIMIT(BIT_LIMIT)) uCtrl (
    .clk(clk), .rstN(rstN), .opCode(opCode), .addr(opAddr), .selBit(selBit),
    .strb(strb), .skip(skipOut), .illegal(illegalOut)
  );

  iobit_datapath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .BIT_LIMIT(BIT_LIMIT)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(opAddr), .idx(bitIdx),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .selBit(selBit)
  );

endmodule

// File: tb/iobit_unit_test.sv
module iobit_unit_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] opCode = 3'd0;
  logic [5:0] opAddr = '0;
  logic [2:0] bitIdx = '0;
  logic [7:0] wrData = '0;
  logic [5:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       skipOut, illegalOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  int model [64];
  int expSkip = 0;
  int expIll = 0;

  always #5 clk = ~clk;

  iobit_unit uut (
    .clk(clk), .rstN(rstN), .opCode(opCode), .opAddr(opAddr), .bitIdx(bitIdx),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .skipOut(skipOut), .illegalOut(illegalOut)
  );

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one operation; compares flags and the read port at the next falling edge
  task automatic step(string req, int op, int a, int b, int d, int ra);
    int bitv;
    opCode = op[2:0]; opAddr = a[5:0]; bitIdx = b[2:0]; wrData = d[7:0]; rdAddr = ra[5:0];
    @(posedge clk);
    bitv = (model[a] >> b) & 1;
    expSkip = 0; expIll = 0;
    if (op >= 1 && op <= 4 && a >= 32) expIll = 1;
    else begin
      case (op)
        1: model[a] = model[a] | (1 << b);
        2: model[a] = model[a] & ~(1 << b);
        3: expSkip = bitv;
        4: expSkip = 1 - bitv;
        5: model[a] = d & 8'hff;
        default: ;
      endcase
    end
    @(negedge clk);
    check(req, "skipOut", int'(skipOut), expSkip);
    check(req, "illegalOut", int'(illegalOut), expIll);
    check(req, "rdData", int'(rdData), model[ra]);
  endtask

  task automatic sweep(string req);
    opCode = 3'd0;
    for (int i = 0; i < 64; i++) begin
      rdAddr = i[5:0];
      #1;
      check(req, "bank sweep", int'(rdData), model[i]);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "skipOut", int'(skipOut), 0);
    check("R1", "illegalOut", int'(illegalOut), 0);
    sweep("R1");

    // R2 byte writes on low, boundary and top addresses
    step("R2", 5, 0, 0, 8'h59, 0);
    step("R2", 5, 31, 0, 8'hA5, 31);
    step("R2", 5, 32, 0, 8'h3C, 32);
    step("R2", 5, 63, 0, 8'hFF, 63);

    // R3 set bits 2,5,6 on 0x59 -> 0x7D
    step("R3", 1, 0, 2, 0, 0);
    step("R3", 1, 0, 5, 0, 0);
    step("R3", 1, 0, 6, 0, 0);
    check("R3", "set result", int'(rdData), 8'h7D);
    // R4 clear bits 2,5,6 -> 0x19
    step("R4", 2, 0, 2, 0, 0);
    step("R4", 2, 0, 5, 0, 0);
    step("R4", 2, 0, 6, 0, 0);
    check("R4", "clear result", int'(rdData), 8'h19);
    step("R4", 2, 31, 7, 0, 31);
    step("R3", 1, 31, 1, 0, 31);
    sweep("R5");

    // R6 / R7 tests, back to back
    step("R6", 3, 0, 3, 0, 0);
    step("R6", 3, 0, 2, 0, 0);
    step("R7", 4, 0, 2, 0, 0);
    step("R7", 4, 0, 3, 0, 0);
    step("R6", 3, 31, 0, 0, 31);
    step("R9", 0, 0, 0, 0, 0);
    check("R6", "skip one cycle", int'(skipOut), 0);

    // R8 out-of-range bit ops
    step("R8", 1, 32, 6, 0, 32);
    step("R8", 2, 63, 0, 0, 63);
    step("R8", 3, 63, 7, 0, 63);
    step("R8", 4, 32, 6, 0, 32);
    step("R9", 0, 32, 0, 0, 32);
    check("R8", "illegal one cycle", int'(illegalOut), 0);
    sweep("R8");

    // R9 unused codes
    step("R9", 6, 3, 1, 8'hEE, 3);
    step("R9", 7, 40, 1, 8'hEE, 40);
    sweep("R9");

    // random stream
    for (int n = 0; n < 400; n++) begin
      int op, a;
      op = $urandom_range(0, 7);
      a  = $urandom_range(0, 63);
      step("R5", op, a, $urandom_range(0, 7), $urandom_range(0, 255),
           (n % 2 == 0) ? a : $urandom_range(0, 63));
    end
    sweep("R5");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule